// File: doc/BRIEF.md
# BCD Clock Calendar with Century Bit

This block keeps wall-clock time and calendar date as seven packed-BCD registers: seconds, minutes, hours (24-hour), day of week, day of month, month and two-digit year. A free-running oscillator strobe (`osc_stb`) feeds an internal prescaler. Every `STROBES_PER_SEC` strobes the prescaler emits one one-second step, and that step ripples through the time and date fields. The date fields handle short months and leap-year February. Bit 7 of the hours register is a century-enable flag and bit 6 is a century flag that flips when the year wraps.

Software or a bus controller loads any register through a one-byte write port at addresses 0 to 6. All seven registers are always visible on parallel outputs. Bit 7 of the seconds register stops timekeeping. A write to the seconds register also restarts the sub-second prescaler, so the next step comes exactly one full second after the write.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the outputs are sec 00 (timekeeping enabled), min 00, hour 00 with both century bits 0, day-of-week 1, date 01, month 01 and year 00.
- R2: One second step happens per `STROBES_PER_SEC` strobes. Seconds run 00–59 and carry into minutes. Minutes run 00–59 and carry into hours. Hours run 00–23. Without a strobe or a write, every output holds its value.
- R3: A write loads one register. Address 0: bit 7 is the stop flag and bits 6:0 are seconds. Address 1: minutes in bits 6:0. Address 2: bit 7 century-enable, bit 6 century, bits 5:0 hours. Address 3: day-of-week in bits 2:0. Address 4: date in bits 5:0. Address 5: month in bits 4:0. Address 6: year in bits 7:0.
- R4: Bit positions outside the fields of R3 read as 0. A write to address 7 changes nothing.
- R5: A write to address 0 restarts the prescaler. No step occurs in the cycle of that write, even if a strobe arrives in the same cycle. The next step comes after exactly `STROBES_PER_SEC` further strobes.
- R6: While seconds bit 7 is 1, strobes change nothing. Once the bit is written back to 0, counting resumes.
- R7: Day-of-week advances only on the step from 23:59:59. It goes from 7 back to 1.
- R8: At midnight the date wraps to 01 after the month's last day, and the month then advances. The last day is 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11.
- R9: February ends on day 29 when the BCD year is divisible by 4 (including 00), and on day 28 otherwise.
- R10: The step from 31 December of year 99 gives 01 January of year 00. The century bit flips on that step only when century-enable is 1.
- R11: If a write and a step arrive in the same cycle, the written register takes the written value. Every other register still takes its stepped value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| osc_stb | input | 1 | One-cycle oscillator strobe that feeds the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address of the write |
| wr_data | input | 8 | Write byte |
| sec_o | output | 8 | Stop flag and seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Century-enable, century and hours |
| dow_o | output | 8 | Day of week |
| date_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year |

## Verification
Assertions check these on every cycle:
- The registers stay frozen when there is no strobe and no write, and while the stop flag is set.
- Writes to seconds, minutes and year load exactly the written bits.
- Day-of-week changes only on a step out of 23:59:59.
- The century pair never changes while century-enable is clear.

Some behaviour depends on the calendar arithmetic or on the prescaler phase, so only the bench scenarios can show it:
- The last-day table for each month and the leap-year rule over all hundred years.
- The restart of the prescaler after a seconds write.
- The write-over-step priority.
- A complete hour of second-by-second stepping.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int unsigned TIME_FIELDS = 3;

  localparam logic [2:0] ADDR_SEC   = 3'd0;
  localparam logic [2:0] ADDR_HOUR  = 3'd2;
  localparam logic [2:0] ADDR_DOW   = 3'd3;
  localparam logic [2:0] ADDR_DATE  = 3'd4;
  localparam logic [2:0] ADDR_MONTH = 3'd5;
  localparam logic [2:0] ADDR_YEAR  = 3'd6;

  // Packed two-digit BCD increment. Callers handle the wrap value themselves.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    else                return {v[7:4], v[3:0] + 4'h1};
  endfunction

  // A BCD year is divisible by 4 when (2*odd_tens + ones) mod 4 == 0.
  function automatic logic is_leap(input logic tens_odd, input logic [1:0] ones_lo);
    logic [1:0] r;
    r = ones_lo + {tens_odd, 1'b0};
    return (r == 2'b00);
  endfunction

  // Last day of a month, in BCD.
  function automatic logic [5:0] last_day(input logic [4:0] mon, input logic leap);
    case (mon)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_stb,
  input  logic halt,
  input  logic restart,
  output logic sec_tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          at_last;

  assign at_last  = (cnt_q == LAST);
  assign sec_tick = osc_stb & ~halt & ~restart & at_last;
  assign cnt_en   = restart | (osc_stb & ~halt);

  always_comb begin
    if (restart)      cnt_d = '0;
    else if (at_last) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cal_time_chain.sv
module cal_time_chain
  import cal_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sec_tick,
  input  logic                      wr_en,
  input  logic [2:0]                wr_addr,
  input  logic [7:0]                wr_data,
  output logic                      osc_off,
  output logic [TIME_FIELDS*8-1:0]  fields,
  output logic                      midnight
);
  localparam int unsigned NF = TIME_FIELDS;
  // Field i sits at [i*8 +: 8]: seconds, minutes, hours.
  localparam logic [NF*8-1:0] TOPS  = {8'h23, 8'h59, 8'h59};
  localparam logic [NF*8-1:0] MASKS = {8'h3F, 8'h7F, 8'h7F};

  logic [NF-1:0] at_top;
  logic [NF:0]   step;

  // step[i] is the advance request into field i; it ripples while fields sit at their top value.
  always_comb begin
    logic c;
    c = sec_tick;
    for (int i = 0; i < NF; i++) begin
      step[i] = c;
      c = c & at_top[i];
    end
    step[NF] = c;
  end

  assign midnight = step[NF];

  for (genvar i = 0; i < NF; i++) begin : g_fld
    logic [7:0] q, d;
    logic       hit;

    assign at_top[i] = (q == TOPS[i*8 +: 8]);
    assign hit       = wr_en && (wr_addr == 3'(i));

    always_comb begin
      d = q;
      if (step[i]) d = at_top[i] ? 8'h00 : bcd_inc(q);
      if (hit)     d = wr_data & MASKS[i*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             q <= 8'h00;
      else if (step[i] | hit) q <= d;
    end

    assign fields[i*8 +: 8] = q;
  end

  logic osc_we;
  assign osc_we = wr_en && (wr_addr == ADDR_SEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      osc_off <= 1'b0;
    else if (osc_we) osc_off <= wr_data[7];
  end
endmodule

// File: rtl/cal_date_chain.sv
module cal_date_chain
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_tick,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [2:0] dow,
  output logic [5:0] date,
  output logic [4:0] month,
  output logic [7:0] year,
  output logic       cen_en,
  output logic       century
);
  logic [2:0] dow_d;
  logic [5:0] date_d;
  logic [4:0] month_d;
  logic [7:0] year_d;
  logic       cen_en_d, century_d;
  logic       date_end, month_end, year_end;
  logic       we_dow, we_date, we_month, we_year, we_hour;
  logic       step_month, step_year;

  assign date_end   = (date == last_day(month, is_leap(year[4], year[1:0])));
  assign month_end  = date_end & (month == 5'h12);
  assign year_end   = month_end & (year == 8'h99);
  assign step_month = day_tick & date_end;
  assign step_year  = day_tick & month_end;

  assign we_dow   = wr_en && (wr_addr == ADDR_DOW);
  assign we_date  = wr_en && (wr_addr == ADDR_DATE);
  assign we_month = wr_en && (wr_addr == ADDR_MONTH);
  assign we_year  = wr_en && (wr_addr == ADDR_YEAR);
  assign we_hour  = wr_en && (wr_addr == ADDR_HOUR);

  always_comb begin
    dow_d     = dow;
    date_d    = date;
    month_d   = month;
    year_d    = year;
    cen_en_d  = cen_en;
    century_d = century;
    if (day_tick) begin
      dow_d  = (dow == 3'd7) ? 3'd1 : dow + 3'd1;
      date_d = date_end ? 6'h01 : 6'(bcd_inc({2'b00, date}));
    end
    if (step_month) month_d = (month == 5'h12) ? 5'h01 : 5'(bcd_inc({3'b000, month}));
    if (step_year)  year_d  = year_end ? 8'h00 : bcd_inc(year);
    if (step_year && year_end && cen_en) century_d = ~century;
    if (we_dow)   dow_d   = wr_data[2:0];
    if (we_date)  date_d  = wr_data[5:0];
    if (we_month) month_d = wr_data[4:0];
    if (we_year)  year_d  = wr_data;
    if (we_hour) begin
      cen_en_d  = wr_data[7];
      century_d = wr_data[6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dow <= 3'd1; date <= 6'h01; month <= 5'h01; year <= 8'h00;
      cen_en <= 1'b0; century <= 1'b0;
    end else begin
      if (day_tick | we_dow)    dow   <= dow_d;
      if (day_tick | we_date)   date  <= date_d;
      if (step_month | we_month) month <= month_d;
      if (step_year | we_year)  year  <= year_d;
      if (step_year | we_hour) begin
        cen_en  <= cen_en_d;
        century <= century_d;
      end
    end
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int unsigned STROBES_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_stb,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);
  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic                     sec_tick, midnight, osc_off, sec_write;
  logic [TIME_FIELDS*8-1:0] tfields;
  logic [2:0]               dow;
  logic [5:0]               date;
  logic [4:0]               month;
  logic [7:0]               year;
  logic                     cen_en, century;

  assign sec_write = wr_en && (wr_addr == ADDR_SEC);

  cal_prescaler #(.DIV(STROBES_PER_SEC)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .osc_stb(osc_stb), .halt(osc_off),
    .restart(sec_write), .sec_tick(sec_tick)
  );

  cal_time_chain u_time (
    .clk(clk), .rst_n(rst_sync_n), .sec_tick(sec_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .osc_off(osc_off),
    .fields(tfields), .midnight(midnight)
  );

  cal_date_chain u_date (
    .clk(clk), .rst_n(rst_sync_n), .day_tick(midnight), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .dow(dow), .date(date),
    .month(month), .year(year), .cen_en(cen_en), .century(century)
  );

  assign sec_o   = {osc_off, 7'(tfields[7:0])};
  assign min_o   = tfields[15:8];
  assign hour_o  = {cen_en, century, 6'(tfields[23:16])};
  assign dow_o   = {5'b00000, dow};
  assign date_o  = {2'b00, date};
  assign month_o = {3'b000, month};
  assign year_o  = year;
endmodule

// File: rtl/cal_checker.sv
module cal_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       osc_stb,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] dow_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o
);
  p_quiet_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_stb && !wr_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
      $stable(dow_o) && $stable(date_o) && $stable(month_o) && $stable(year_o)));

  p_stopped_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o[7] && !wr_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
      $stable(dow_o) && $stable(date_o) && $stable(month_o) && $stable(year_o)));

  p_sec_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> (sec_o == $past(wr_data)));

  p_year_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd6) |=> (year_o == $past(wr_data)));

  p_min_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd1) |=> (min_o == {1'b0, $past(wr_data[6:0])}));

  p_dow_midnight_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> ($stable(dow_o) ||
      ($past(hour_o[5:0]) == 6'h23 && $past(min_o[6:0]) == 7'h59 && $past(sec_o[6:0]) == 7'h59)));

  p_century_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !hour_o[7]) |=> $stable(hour_o[7:6]));
endmodule

bind bcd_calendar cal_checker u_chk (.*);

// File: tb/tb_bcd_calendar.sv
`timescale 1ns/1ps
module tb_bcd_calendar;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n, osc_stb, wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;

  always #2.5 clk = ~clk;

  bcd_calendar #(.STROBES_PER_SEC(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .osc_stb(osc_stb), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // Reference model, in plain integers.
  int m_s = 0, m_m = 0, m_h = 0, m_dow = 1, m_d = 1, m_mo = 1, m_y = 0;
  int m_osc = 0, m_ce = 0, m_c = 0, m_cnt = 0;

  function automatic int mdays(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int unbcd(logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  task automatic model_second();
    m_s++;
    if (m_s == 60) begin
      m_s = 0; m_m++;
      if (m_m == 60) begin
        m_m = 0; m_h++;
        if (m_h == 24) begin
          m_h = 0;
          m_dow = (m_dow == 7) ? 1 : m_dow + 1;
          m_d++;
          if (m_d > mdays(m_mo, m_y)) begin
            m_d = 1; m_mo++;
            if (m_mo > 12) begin
              m_mo = 1; m_y++;
              if (m_y == 100) begin
                m_y = 0;
                if (m_ce != 0) m_c = 1 - m_c;
              end
            end
          end
        end
      end
    end
  endtask

  task automatic model_write(logic [2:0] a, logic [7:0] v);
    case (a)
      3'd0: begin m_osc = int'(v[7]); m_s = unbcd({1'b0, v[6:0]}); end
      3'd1: m_m = unbcd({1'b0, v[6:0]});
      3'd2: begin m_ce = int'(v[7]); m_c = int'(v[6]); m_h = unbcd({2'b00, v[5:0]}); end
      3'd3: m_dow = int'(v[2:0]);
      3'd4: m_d = unbcd({2'b00, v[5:0]});
      3'd5: m_mo = unbcd({3'b000, v[4:0]});
      3'd6: m_y = unbcd(v);
      default: ;
    endcase
  endtask

  function automatic logic [55:0] expected();
    return {bcd(m_s) | 8'(m_osc << 7), bcd(m_m), bcd(m_h) | 8'(m_ce << 7) | 8'(m_c << 6),
            8'(m_dow), bcd(m_d), bcd(m_mo), bcd(m_y)};
  endfunction

  task automatic check_all(string tag);
    logic [55:0] act, exp;
    act = {sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o};
    exp = expected();
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle of stimulus: inputs change on the falling edge, results are read one falling edge later.
  task automatic drive(bit stb, bit we, logic [2:0] a, logic [7:0] v, string tag);
    osc_stb = stb; wr_en = we; wr_addr = a; wr_data = v;
    if (we && a == 3'd0) m_cnt = 0;
    else if (stb && m_osc == 0) begin
      if (m_cnt == DIV - 1) begin m_cnt = 0; model_second(); end
      else m_cnt++;
    end
    if (we) model_write(a, v);
    @(negedge clk);
    osc_stb = 0; wr_en = 0;
    check_all(tag);
  endtask

  task automatic strobes(int n, string tag);
    for (int i = 0; i < n; i++) drive(1, 0, 3'd0, 8'h00, tag);
  endtask

  task automatic set_all(int s, int m, int h, int dw, int dd, int mo, int y, int ce, int c, string tag);
    drive(0, 1, 3'd1, bcd(m), tag);
    drive(0, 1, 3'd2, bcd(h) | 8'(ce << 7) | 8'(c << 6), tag);
    drive(0, 1, 3'd3, 8'(dw), tag);
    drive(0, 1, 3'd4, bcd(dd), tag);
    drive(0, 1, 3'd5, bcd(mo), tag);
    drive(0, 1, 3'd6, bcd(y), tag);
    drive(0, 1, 3'd0, bcd(s), tag);
  endtask

  task automatic midnight_case(int dd, int mo, int y, int dw, int ce, int c, string tag);
    set_all(59, 59, 23, dw, dd, mo, y, ce, c, tag);
    strobes(DIV, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; osc_stb = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_all("R1 reset state");

    // R2: a full hour stepped second by second from reset
    strobes(3600 * DIV, "R2 hour sweep");
    // R2: every hour carry, including 23 -> 00
    for (int hr = 0; hr < 24; hr++) begin
      set_all(59, 59, hr, 2, 15, 6, 21, 0, 0, "R2 hour carry");
      strobes(DIV, "R2 hour carry");
    end

    // R3 / R4: field loads, unused bits, address 7
    set_all(7, 8, 9, 5, 17, 11, 42, 1, 0, "R3 load");
    drive(0, 1, 3'd7, 8'hFF, "R4 addr7 ignored");
    drive(0, 1, 3'd1, 8'hA5, "R4 min bit7 dropped");
    drive(0, 1, 3'd3, 8'hFE, "R4 dow upper bits dropped");
    drive(0, 1, 3'd3, 8'h04, "R3 dow reload");

    // R5: prescaler restart on seconds write
    strobes(DIV - 2, "R5 partial");
    drive(0, 1, 3'd0, 8'h30, "R5 sec write");
    strobes(DIV - 1, "R5 no early step");
    strobes(1, "R5 step after full count");
    strobes(DIV - 1, "R5 partial again");
    drive(1, 1, 3'd0, 8'h40, "R5 write with strobe no step");
    strobes(DIV, "R5 full count");

    // R6: stop flag
    drive(0, 1, 3'd0, 8'h90, "R6 stop");
    strobes(3 * DIV, "R6 frozen");
    drive(0, 1, 3'd0, 8'h10, "R6 resume");
    strobes(2 * DIV, "R6 running");

    // R7: day-of-week wrap and no change away from midnight
    midnight_case(10, 3, 5, 7, 0, 0, "R7 dow 7 to 1");
    midnight_case(10, 3, 5, 3, 0, 0, "R7 dow 3 to 4");
    set_all(59, 59, 22, 6, 10, 3, 5, 0, 0, "R7 no change at 22:59:59");
    strobes(DIV, "R7 no change at 22:59:59");

    // R8: last day of each month in a common and a leap year
    for (int yi = 0; yi < 2; yi++) begin
      for (int mo = 1; mo <= 12; mo++) begin
        int y;
        y = (yi == 0) ? 1 : 4;
        midnight_case(mdays(mo, y), mo, y, 1, 0, 0, "R8 month end");
        midnight_case(mdays(mo, y) - 1, mo, y, 1, 0, 0, "R8 day before month end");
      end
    end

    // R9: February 28 over all hundred years
    for (int y = 0; y < 100; y++) midnight_case(28, 2, y, 2, 0, 0, "R9 feb 28");

    // R10: year and century wrap
    midnight_case(31, 12, 99, 1, 1, 0, "R10 century set");
    midnight_case(31, 12, 99, 1, 1, 1, "R10 century clear");
    midnight_case(31, 12, 99, 1, 0, 1, "R10 century held");
    midnight_case(31, 12, 98, 1, 1, 0, "R10 no toggle at 98");

    // R11: minutes written in the cycle of a carrying step
    set_all(59, 20, 10, 3, 12, 7, 33, 0, 0, "R11 setup");
    strobes(DIV - 1, "R11 setup");
    drive(1, 1, 3'd1, 8'h45, "R11 write beats step");
    set_all(59, 59, 10, 3, 12, 7, 33, 0, 0, "R11 setup2");
    strobes(DIV - 1, "R11 setup2");
    drive(1, 1, 3'd6, 8'h50, "R11 year write with carry");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule